// File: doc/BRIEF.md
# Full-Period Shift-Register Sequence Counter

This block is a linear-feedback shift-register counter whose width is set by a parameter (2 to 8 bits). On every enabled clock the state shifts one place toward bit 0. The vacated top bit takes a feedback value. That value is the odd parity of a fixed set of tap stages, and the tap set always includes bit 0 and always has an even number of members. In its basic mode the counter runs through the 2^W−1 nonzero states before it repeats.

A mode parameter turns on a zero-insertion term. This term XORs the parity with the NOR of every stage except bit 0. The effect is that the all-zero state is spliced into the cycle right after state 0…01, so the counter visits all 2^W codes. Uses include cheap pseudo-random sequencing, address stepping and dividers where a binary adder is too deep.

A synchronous reset loads a seed value, and an enable input freezes the state when it is low. A one-clock wrap flag marks each return to the seed.

Top module: `lfsr_counter`

## Requirements
- R1: While `rst` is high at a rising edge the state loads the SEED parameter (default 4'b0001) and `wrap` is 0 after that edge.
- R2: On an enabled step (rst low, en high) the state shifts right: new bits [W-2:0] equal old bits [W-1:1].
- R3: In basic mode the new top bit is the XOR of the tap stages; for W=4 the taps are bits 1 and 0, so from seed 0001 the states run 1000, 0100, 0010, 1001, 1100, 0110, 1011, 0101, 1010, 1101, 1110, 1111, 0111, 0011, 0001.
- R4: In full mode the new top bit is the tap parity XOR the NOR of bits [W-1:1]; for W=4 state 0001 is followed by 0000 and 0000 by 1000, and every other step matches R3.
- R5: In full mode the state returns to the seed after exactly 2^W enabled steps and every one of the 2^W codes appears once (checked for W=4 and W=8; W=8 taps are bits 4, 3, 2 and 0).
- R6: In basic mode, from a nonzero seed, the state is never all-zero and repeats after exactly 2^W−1 enabled steps.
- R7: With rst low and en low the state is held and `wrap` is 0.
- R8: Reset takes priority over enable: rst and en both high loads the seed.
- R9: `wrap` is high for exactly the one cycle after an enabled step that lands on the seed, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the seed |
| en | input | 1 | Step enable; low holds the state |
| state | output | WIDTH | Current counter state, bit 0 is the last stage |
| wrap | output | 1 | One-cycle pulse when a step returns to the seed |

## Verification
The assertions assume that `rst` is high from time zero through the first edges and that WIDTH lies in the tap table's range of 2 to 8. They also assume that in basic mode the seed is nonzero, because the no-zero check would fail from an all-zero seed. The bench starts every instance in reset and uses only nonzero seeds. It changes `rst` and `en` one nanosecond after a rising edge, so each input is a stable level when the assertions sample it.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    localparam int unsigned LFSR_MAX_W = 8;

    typedef enum logic {
        LFSR_MAXLEN = 1'b0,
        LFSR_FULL   = 1'b1
    } lfsr_mode_e;

    typedef struct packed {
        logic load;
        logic advance;
    } lfsr_ctl_t;

    // Tap stages feeding the parity term, bit k set means stage Xk is a tap.
    // Every entry holds bit 0 and an even count of taps.
    function automatic logic [LFSR_MAX_W-1:0] tap_mask(input int unsigned w);
        logic [LFSR_MAX_W-1:0] m;
        case (w)
            2:       m = 8'b0000_0011;
            3:       m = 8'b0000_0011;
            4:       m = 8'b0000_0011;
            5:       m = 8'b0000_0101;
            6:       m = 8'b0000_0011;
            7:       m = 8'b0000_0011;
            8:       m = 8'b0001_1101;
            default: m = 8'b0000_0011;
        endcase
        return m;
    endfunction

    function automatic lfsr_ctl_t decode_ctl(input logic rst, input logic en);
        lfsr_ctl_t c;
        c.load    = rst;
        c.advance = ~rst & en;
        return c;
    endfunction

endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback
    import lfsr_pkg::*;
#(
    parameter int unsigned          WIDTH = 4,
    parameter lfsr_mode_e           MODE  = LFSR_FULL,
    parameter logic [WIDTH-1:0]     TAPS  = '1
) (
    input  logic [WIDTH-1:0] cur,
    output logic             fb
);
    logic parity;

    assign parity = ^(cur & TAPS);

    generate
        if (MODE == LFSR_FULL) begin : g_full
            logic upper_zero;
            assign upper_zero = ~|cur[WIDTH-1:1];
            assign fb = parity ^ upper_zero;
        end else begin : g_maxlen
            assign fb = parity;
        end
    endgenerate
endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg
    import lfsr_pkg::*;
#(
    parameter int unsigned      WIDTH = 4,
    parameter logic [WIDTH-1:0] SEED  = 1
) (
    input  logic             clk,
    input  lfsr_ctl_t        ctl,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (ctl.load) begin
            q <= SEED;
        end else if (ctl.advance) begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/lfsr_wrap_detect.sv
module lfsr_wrap_detect
    import lfsr_pkg::*;
#(
    parameter int unsigned      WIDTH = 4,
    parameter logic [WIDTH-1:0] SEED  = 1
) (
    input  logic             clk,
    input  lfsr_ctl_t        ctl,
    input  logic [WIDTH-1:0] nxt,
    output logic             wrap
);
    logic hit;

    assign hit = (nxt == SEED);

    always_ff @(posedge clk) begin
        if (ctl.load) begin
            wrap <= 1'b0;
        end else begin
            wrap <= ctl.advance & hit;
        end
    end
endmodule

// File: rtl/lfsr_counter.sv
module lfsr_counter
    import lfsr_pkg::*;
#(
    parameter int unsigned      WIDTH = 4,
    parameter lfsr_mode_e       MODE  = LFSR_FULL,
    parameter logic [WIDTH-1:0] SEED  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] state,
    output logic             wrap
);
    localparam logic [LFSR_MAX_W-1:0] TAPS_ALL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0]      TAPS     = TAPS_ALL[WIDTH-1:0];

    lfsr_ctl_t        ctl;
    logic             fb;
    logic [WIDTH-1:0] nxt;

    assign ctl = decode_ctl(rst, en);
    assign nxt = {fb, state[WIDTH-1:1]};

    lfsr_feedback #(
        .WIDTH (WIDTH),
        .MODE  (MODE),
        .TAPS  (TAPS)
    ) u_fb (
        .cur (state),
        .fb  (fb)
    );

    lfsr_state_reg #(
        .WIDTH (WIDTH),
        .SEED  (SEED)
    ) u_reg (
        .clk (clk),
        .ctl (ctl),
        .nxt (nxt),
        .q   (state)
    );

    lfsr_wrap_detect #(
        .WIDTH (WIDTH),
        .SEED  (SEED)
    ) u_wrap (
        .clk  (clk),
        .ctl  (ctl),
        .nxt  (nxt),
        .wrap (wrap)
    );
endmodule

// File: rtl/lfsr_counter_checker.sv
module lfsr_counter_checker
    import lfsr_pkg::*;
#(
    parameter int unsigned      WIDTH = 4,
    parameter lfsr_mode_e       MODE  = LFSR_FULL,
    parameter logic [WIDTH-1:0] SEED  = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [WIDTH-1:0] state,
    input logic             wrap
);
    localparam logic [LFSR_MAX_W-1:0] CK_TAPS_ALL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0]      CK_TAPS     = CK_TAPS_ALL[WIDTH-1:0];
    localparam logic                  CK_FULL     = (MODE == LFSR_FULL);

    function automatic logic top_bit(input logic [WIDTH-1:0] s);
        return (^(s & CK_TAPS)) ^ (CK_FULL & (s[WIDTH-1:1] == '0));
    endfunction

    // R1: reset leaves the seed and a quiet wrap flag
    p_reset_seed_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == SEED && !wrap));

    // R2: right shift toward stage 0
    p_shift_right_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));

    // R3 and R4: top bit takes parity, plus zero insertion in full mode
    p_top_feedback_r4: assert property (@(posedge clk) disable iff (rst)
        en |=> state[WIDTH-1] == top_bit($past(state)));

    // R6: basic mode never reaches the all-zero code
    p_no_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !CK_FULL |-> state != '0);

    // R7: disabled cycles hold the state and keep wrap low
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(state) && !wrap));

    // R9: wrap only while sitting on the seed, never two cycles running
    p_wrap_at_seed_r9: assert property (@(posedge clk) disable iff (rst)
        wrap |-> state == SEED);

    p_wrap_single_r9: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);
endmodule

bind lfsr_counter lfsr_counter_checker #(
    .WIDTH (WIDTH),
    .MODE  (MODE),
    .SEED  (SEED)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .state (state),
    .wrap  (wrap)
);

// File: tb/test_lfsr_counter.sv
`timescale 1ns/1ps
module test_lfsr_counter;
    import lfsr_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [3:0] st_f, st_p;
    logic [7:0] st_w;
    logic       wr_f, wr_p, wr_w;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lfsr_counter #(.WIDTH(4), .MODE(LFSR_FULL), .SEED(4'b0001)) i_lfsr_counter (
        .clk(clk), .rst(rst), .en(en), .state(st_f), .wrap(wr_f));
    lfsr_counter #(.WIDTH(4), .MODE(LFSR_MAXLEN), .SEED(4'b0001)) u_plain (
        .clk(clk), .rst(rst), .en(en), .state(st_p), .wrap(wr_p));
    lfsr_counter #(.WIDTH(8), .MODE(LFSR_FULL), .SEED(8'h01)) u_wide (
        .clk(clk), .rst(rst), .en(en), .state(st_w), .wrap(wr_w));

    // R4 full-mode W=4 sequence after each step from seed 0001, wrap on the last
    localparam logic [4:0] VEC [16] = '{
        5'b0000_0, 5'b1000_0, 5'b0100_0, 5'b0010_0,
        5'b1001_0, 5'b1100_0, 5'b0110_0, 5'b1011_0,
        5'b0101_0, 5'b1010_0, 5'b1101_0, 5'b1110_0,
        5'b1111_0, 5'b0111_0, 5'b0011_0, 5'b0001_1};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] plain_next(input logic [3:0] s);
        return {s[1] ^ s[0], s[3:1]};
    endfunction

    function automatic logic [7:0] wide_next(input logic [7:0] s);
        return {s[4] ^ s[3] ^ s[2] ^ s[0] ^ (s[7:1] == 7'd0), s[7:1]};
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] pm;
        logic [7:0] wm;
        logic [255:0] seen;
        int wraps, distinct;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(st_f == 4'b0001, "R1 seed", st_f, 1);
        chk(!wr_f && !wr_p, "R1 wrap low", {wr_f, wr_p}, 0);

        // table walk: full and basic run side by side
        en = 1'b1;
        pm = 4'b0001;
        for (int i = 0; i < 16; i++) begin
            tick();
            pm = plain_next(pm);
            chk(st_f == VEC[i][4:1], "R4 full sequence", st_f, VEC[i][4:1]);
            chk(wr_f == VEC[i][0], "R9 full wrap", wr_f, VEC[i][0]);
            chk(st_p == pm, "R3 basic sequence", st_p, pm);
            chk(wr_p == (pm == 4'b0001), "R9 basic wrap", wr_p, (pm == 4'b0001));
            chk(st_f[2:0] == (i == 0 ? 3'b000 : VEC[i-1][4:2]), "R2 shift", st_f, VEC[i][4:1]);
        end

        // R7 hold with en low
        en = 1'b0;
        repeat (3) begin
            tick();
            chk(st_f == 4'b0001, "R7 hold full", st_f, 1);
            chk(st_p == pm, "R7 hold basic", st_p, pm);
            chk(!wr_f, "R7 wrap low while held", wr_f, 0);
        end

        // R8 reset beats enable mid-sequence
        en = 1'b1;
        repeat (5) tick();
        rst = 1'b1;
        tick();
        chk(st_f == 4'b0001, "R8 reset priority full", st_f, 1);
        chk(st_w == 8'h01, "R8 reset priority wide", st_w, 1);
        chk(!wr_f, "R8 wrap low", wr_f, 0);
        rst = 1'b0;

        // R5 and R6 long run
        pm = 4'b0001; wm = 8'h01; seen = '0; wraps = 0; distinct = 0;
        seen[1] = 1'b1; distinct = 1;
        for (int i = 1; i <= 256; i++) begin
            tick();
            pm = plain_next(pm);
            wm = wide_next(wm);
            if (st_w != wm) chk(0, "R5 wide sequence", st_w, wm);
            if (st_p == 4'd0) chk(0, "R6 basic reached zero", st_p, 1);
            if (wr_w) wraps++;
            if (i < 256 && !seen[st_w]) begin
                seen[st_w] = 1'b1;
                distinct++;
            end
            if (i == 15) chk(st_p == 4'b0001, "R6 basic period", st_p, 1);
            if (i == 16) chk(st_f == 4'b0001 && wr_f, "R5 full period 16", st_f, 1);
        end
        chk(distinct == 256, "R5 wide all codes", distinct, 256);
        chk(wraps == 1 && wr_w && st_w == 8'h01, "R5 wide period 256", wraps, 1);
        chk(st_p != 4'd0, "R6 basic nonzero", st_p, 1);

        // R9 wrap drops when stepping stops on the seed
        en = 1'b0;
        tick();
        chk(!wr_w, "R9 wrap one cycle", wr_w, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule